// File: doc/BRIEF.md
# External Bus Hand-Over Arbiter

This block decides when an outside bus master may take over the processor's external address bus, data bus and strobes. It samples a bus-request input together with the core's view of its external accesses, which is whether an access is running and whether this is its final cycle. It hands the bus over only at a safe cycle boundary. While the bus is given away, the block drives its interface three-stated, raises bus grant and, depending on a mode input, stops the core. When the request goes away, the grant is withdrawn, and the drivers come back a configurable number of cycles later.

The hand-over does not wait for an instruction to finish. An instruction that makes two external accesses can lose the bus between them. In the continue-running mode, the core is not stopped while the bus is away. It is held only once it reports that it needs the external bus.

Top module: `xbus_arb`

## Requirements
- R1: After reset, bus_grant is 0, bus_drv_en is 1, core_halt is 0 and acc_permit is 1.
- R2: While the block owns the bus, with bus_req at 1 and no external access running (acc_busy at 0), bus_grant is 1 in the next cycle.
- R3: Whenever bus_grant is 1, bus_drv_en is 0, so address, data, select and read/write drivers are three-stated.
- R4: A request seen while an access is running and acc_done is 0 is not granted in the next cycle. It is granted in the cycle right after the cycle in which acc_done is 1.
- R5: With go_mode at 0, core_halt is 1 in every cycle where bus_grant is 1.
- R6: With go_mode at 1 and bus_grant at 1, core_halt equals acc_need, so the core runs until it asks for the external bus.
- R7: When bus_req is 0 during a grant, bus_grant is 0 in the next cycle. bus_drv_en stays 0 for GAP_CYC further cycles (default 1) and then returns to 1. In that gap, core_halt equals acc_need.
- R8: acc_permit, the core's permission to start a new external access, is 0 in every cycle where bus_grant is 1 or bus_drv_en is 0.
- R9: A request that arrives in the final cycle of the first of two accesses of one instruction is granted in the next cycle, even though acc_need stays 1. The second access is then held, with core_halt at 1 and acc_permit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | External master asks for the bus |
| acc_busy | input | 1 | Core external access occupies this cycle |
| acc_done | input | 1 | This cycle is the last cycle of the running access |
| acc_need | input | 1 | Core wants to start an external access |
| go_mode | input | 1 | 1: core keeps running while the bus is granted |
| bus_grant | output | 1 | Bus given to the external master |
| bus_drv_en | output | 1 | 1: external interface driven, 0: three-stated |
| core_halt | output | 1 | Stall the core |
| acc_permit | output | 1 | Core may start an external access this cycle |

## Verification
A request with the bus idle separates a one-cycle answer from a late or early grant. A request during a multi-cycle access shows that the grant waits for the final cycle and no longer. A request landing in the last cycle of the first of two back-to-back accesses shows that the bus is taken mid-instruction and the second access is blocked. Each grant is run with go_mode at 0 and at 1, and with acc_need at 0 and at 1, which tells the stop-always behaviour apart from the stop-on-need behaviour. Every release is followed cycle by cycle to confirm that the grant drops first and the drivers return one cycle later.

// File: rtl/xbus_arb_pkg.sv
// Shared types for the external bus hand-over arbiter.
package xbus_arb_pkg;
    // Ownership phase of the external bus.
    typedef enum logic [1:0] {
        PH_OWN     = 2'd0,  // core owns and drives the bus
        PH_GRANTED = 2'd1,  // external master owns the bus
        PH_GAP     = 2'd2   // grant withdrawn, drivers still off
    } bus_phase_t;
endpackage

// File: rtl/xbus_arb_fsm.sv
// Ownership sequencer. Moves the bus between the core and an external
// master. Assumes acc_done is only 1 in the last cycle of an access that
// has acc_busy at 1. GAP_CYC must be at least 1.
module xbus_arb_fsm
    import xbus_arb_pkg::*;
#(
    parameter int GAP_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_req,
    input  logic       acc_busy,
    input  logic       acc_done,
    output bus_phase_t phase
);
    localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    bus_phase_t    phase_q;
    logic [CW-1:0] gap_cnt;
    logic          safe_edge;

    // A hand-over is safe when no access runs past this cycle.
    always_comb safe_edge = !acc_busy || acc_done;

    // Phase register and driver turn-on delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OWN;
            gap_cnt <= '0;
        end else begin
            unique case (phase_q)
                PH_OWN: begin
                    if (bus_req && safe_edge) phase_q <= PH_GRANTED;
                end
                PH_GRANTED: begin
                    if (!bus_req) begin
                        phase_q <= PH_GAP;
                        gap_cnt <= CW'(GAP_CYC - 1);
                    end
                end
                PH_GAP: begin
                    if (gap_cnt == '0) phase_q <= PH_OWN;
                    else               gap_cnt <= gap_cnt - 1'b1;
                end
                default: phase_q <= PH_OWN;
            endcase
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/xbus_arb_halt.sv
// Core-side control. Decides the core stall and whether a new external
// access may start, from the ownership phase. Purely combinational.
module xbus_arb_halt
    import xbus_arb_pkg::*;
(
    input  bus_phase_t phase,
    input  logic       go_mode,
    input  logic       acc_need,
    output logic       core_halt,
    output logic       acc_permit
);
    // Stall: always when granted without go mode, otherwise only on need.
    always_comb begin
        unique case (phase)
            PH_GRANTED: core_halt = !go_mode || acc_need;
            PH_GAP:     core_halt = acc_need;
            default:    core_halt = 1'b0;
        endcase
    end

    // New accesses may start only while the core owns the drivers.
    always_comb acc_permit = (phase == PH_OWN);
endmodule

// File: rtl/xbus_arb.sv
// External bus request/grant arbiter, top level. Grants the external
// bus at a safe cycle boundary, three-states the interface and stalls
// the core as the go mode dictates. Synchronous active-low reset.
module xbus_arb
    import xbus_arb_pkg::*;
#(
    parameter int GAP_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req,
    input  logic acc_busy,
    input  logic acc_done,
    input  logic acc_need,
    input  logic go_mode,
    output logic bus_grant,
    output logic bus_drv_en,
    output logic core_halt,
    output logic acc_permit
);
    bus_phase_t phase;

    xbus_arb_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .acc_busy (acc_busy),
        .acc_done (acc_done),
        .phase    (phase)
    );

    xbus_arb_halt u_halt (
        .phase      (phase),
        .go_mode    (go_mode),
        .acc_need   (acc_need),
        .core_halt  (core_halt),
        .acc_permit (acc_permit)
    );

    // Pin decode of the ownership phase.
    always_comb begin
        bus_grant  = (phase == PH_GRANTED);
        bus_drv_en = (phase == PH_OWN);
    end
endmodule

// File: rtl/xbus_arb_checker.sv
// Port-level properties of the bus arbiter, bound into every instance.
module xbus_arb_checker #(
    parameter int GAP_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic bus_req,
    input logic acc_busy,
    input logic acc_done,
    input logic acc_need,
    input logic go_mode,
    input logic bus_grant,
    input logic bus_drv_en,
    input logic core_halt,
    input logic acc_permit
);
    assert_prompt_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_grant && bus_drv_en && bus_req && (!acc_busy || acc_done)) |=> bus_grant);

    assert_tristate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> !bus_drv_en);

    assert_wait_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_grant && bus_drv_en && acc_busy && !acc_done) |=> !bus_grant);

    assert_halt_nogo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && !go_mode) |-> core_halt);

    assert_halt_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && go_mode) |-> (core_halt == acc_need));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && !bus_req) |=> !bus_grant);

    assert_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant || !bus_drv_en) |-> !acc_permit);

    generate
        if (GAP_CYC == 1) begin : g_gap1
            assert_driver_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(bus_grant) |=> bus_drv_en);
        end
    endgenerate
endmodule

bind xbus_arb xbus_arb_checker #(.GAP_CYC(GAP_CYC)) u_xbus_arb_checker (.*);

// File: tb/xbus_arb_bench.sv
// Directed bench for the external bus arbiter, one task per scenario.
module xbus_arb_bench;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, acc_busy = 1'b0, acc_done = 1'b0;
    logic acc_need = 1'b0, go_mode = 1'b0;
    logic bus_grant, bus_drv_en, core_halt, acc_permit;

    int vectors = 0;
    int misses = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    xbus_arb u_xbus_arb (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .acc_busy(acc_busy),
        .acc_done(acc_done), .acc_need(acc_need), .go_mode(go_mode),
        .bus_grant(bus_grant), .bus_drv_en(bus_drv_en),
        .core_halt(core_halt), .acc_permit(acc_permit)
    );

    task automatic chk(string tag, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one edge and settle past it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        chk("R1 grant", bus_grant, 1'b0);
        chk("R1 drv_en", bus_drv_en, 1'b1);
        chk("R1 halt", core_halt, 1'b0);
        chk("R1 permit", acc_permit, 1'b1);
        rst_n = 1'b1;
        step();
    endtask

    // Drop the request and follow the driver turn-on.
    task automatic release_bus(logic need_exp);
        bus_req = 1'b0;
        step();
        chk("R7 grant drop", bus_grant, 1'b0);
        chk("R7 drv still off", bus_drv_en, 1'b0);
        chk("R8 permit in gap", acc_permit, 1'b0);
        chk("R7 halt in gap", core_halt, need_exp);
        step();
        chk("R7 drv back", bus_drv_en, 1'b1);
        chk("R8 permit back", acc_permit, 1'b1);
    endtask

    task automatic t_idle_grant();
        go_mode = 1'b0; acc_need = 1'b0;
        bus_req = 1'b1;
        step();
        chk("R2 grant next cycle", bus_grant, 1'b1);
        chk("R3 tristate", bus_drv_en, 1'b0);
        chk("R8 permit off", acc_permit, 1'b0);
        chk("R5 halt no go", core_halt, 1'b1);
        step();
        chk("R5 halt held", core_halt, 1'b1);
        release_bus(1'b0);
    endtask

    task automatic t_wait_access();
        acc_busy = 1'b1; acc_done = 1'b0; bus_req = 1'b1;
        step();
        chk("R4 no grant mid access", bus_grant, 1'b0);
        step();
        chk("R4 still waiting", bus_grant, 1'b0);
        acc_done = 1'b1;
        step();
        acc_busy = 1'b0; acc_done = 1'b0;
        chk("R4 grant after final cycle", bus_grant, 1'b1);
        chk("R3 tristate", bus_drv_en, 1'b0);
        release_bus(1'b0);
    endtask

    task automatic t_go_mode();
        go_mode = 1'b1; acc_need = 1'b0; bus_req = 1'b1;
        step();
        chk("R2 grant", bus_grant, 1'b1);
        chk("R6 runs without need", core_halt, 1'b0);
        acc_need = 1'b1; #1;
        chk("R6 halts on need", core_halt, 1'b1);
        acc_need = 1'b0; #1;
        chk("R6 resumes", core_halt, 1'b0);
        release_bus(1'b0);
        go_mode = 1'b0;
    endtask

    task automatic t_split_instr();
        go_mode = 1'b1; acc_need = 1'b1;
        acc_busy = 1'b1; acc_done = 1'b1; bus_req = 1'b1;
        step();
        acc_busy = 1'b0; acc_done = 1'b0; #1;
        chk("R9 grant between accesses", bus_grant, 1'b1);
        chk("R9 second access held", core_halt, 1'b1);
        chk("R9 no start", acc_permit, 1'b0);
        release_bus(1'b1);
        acc_need = 1'b0; #1;
        chk("R1 idle halt", core_halt, 1'b0);
        go_mode = 1'b0;
    endtask

    initial begin
        t_reset();
        t_idle_grant();
        t_wait_access();
        t_go_mode();
        t_split_instr();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            vectors++; misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule